// File: doc/BRIEF.md
# Serial Byte Receiver with Host Read Queue

This block turns an asynchronous serial line into bytes and keeps them in a 16-entry queue until a host reads them. Each frame on the line has one start bit, eight data bits sent least significant first, and one stop bit. The line is sampled on a 16x oversampling enable that comes from outside the block. The host reads the block through one 16-bit word. That word carries the oldest queued byte together with a data-present flag and two sticky error flags. A one-cycle read strobe removes the oldest byte and clears the sticky flags.

The serial side has no back-pressure. A frame is accepted when its stop bit is sampled. If the queue is full at that moment, the byte is dropped and the overrun flag is set. A read strobe is taken as a pop only while data is present. A strobe on an empty queue changes nothing except that it clears the sticky flags. A byte can complete in the same clock edge as a host pop, and both operations then take effect. The interrupt request goes high once data has sat in the queue, unread, for about four frame times. It falls as soon as the queue is empty.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, `rd_word` is 0x0000 and `irq_req` is low.
- R2: A frame with a high stop bit is accepted. Its framing is: start bit low, 8 data bits sent least significant first, then the stop bit, each bit lasting 16 `baud_tick` pulses. Once it is accepted, `rd_word[7:0]` shows the byte and `rd_word[8]` (data present) is 1.
- R3: The start bit is confirmed at its middle. A low pulse on an idle line that is shorter than half a bit leaves the queue empty. A proper frame that follows it is still received.
- R4: The queue holds up to 16 bytes and returns them in arrival order.
- R5: While `rd_word[8]` is 0, `rd_word[7:0]` reads 0x00. A read strobe in that state leaves the queue contents and pointers unchanged.
- R6: If a read strobe pops the queue in the same clock edge as a new byte is written, the head byte is removed and the new byte is kept. No byte is lost or duplicated.
- R7: A frame whose stop bit is sampled low is not queued. It sets the sticky framing flag `rd_word[9]`, which the next read strobe clears.
- R8: A byte that completes while 16 bytes are queued and no pop happens is dropped. It sets the sticky overrun flag `rd_word[10]`. The queued bytes are kept. The next read strobe clears the flag.
- R9: `irq_req` rises once the queue has been non-empty for 640 `baud_tick` pulses in a row (4 frames of 10 bits at 16 ticks per bit). It falls once the queue is empty.
- R10: `rd_word[15:11]` always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_line | input | 1 | Serial receive line, idle high, asynchronous |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_strobe | input | 1 | Host read: pops the head byte and clears the sticky flags |
| rd_word | output | 16 | [7:0] head byte, [8] data present, [9] framing error, [10] overrun, [15:11] zero |
| irq_req | output | 1 | Interrupt request after data has waited in the queue |

## Verification
The hardest case to reach from the ports is a host pop that lands in the exact clock edge where the stop bit is accepted. The internal write happens after an input synchroniser and the receiver's sampling counters, so its cycle cannot be seen from the ports. The stimulus therefore preloads one byte and then sends a second frame. On each run it places a single read strobe one cycle later, sweeping 20 consecutive cycles around the stop-bit sample. After every run exactly the second byte must remain in the queue. Overrun is reached by filling all 16 entries before a 17th frame arrives.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int BYTE_W      = 8;
  localparam int HOST_W      = 16;
  localparam int PRESENT_POS = 8;
  localparam int FRAMING_POS = 9;
  localparam int OVERRUN_POS = 10;

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_STOP
  } line_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  line_state_e       state;
  logic [CNT_W-1:0]  tick_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LINE_IDLE;
      tick_cnt   <= '0;
      bit_idx    <= '0;
      shift_q    <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (tick) begin
        case (state)
          LINE_IDLE: begin
            if (!rx) begin
              state    <= LINE_START;
              tick_cnt <= '0;
            end
          end
          LINE_START: begin
            if (tick_cnt == MID_CNT) begin
              tick_cnt <= '0;
              bit_idx  <= '0;
              state    <= rx ? LINE_IDLE : LINE_DATA;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          LINE_DATA: begin
            if (tick_cnt == LAST_CNT) begin
              tick_cnt <= '0;
              shift_q  <= {rx, shift_q[DATA_W-1:1]};
              if (bit_idx == LAST_IDX) state <= LINE_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          default: begin
            if (tick_cnt == LAST_CNT) begin
              tick_cnt <= '0;
              state    <= LINE_IDLE;
              if (rx) byte_valid <= 1'b1;
              else    frame_err  <= 1'b1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign byte_data = shift_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R3
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LINE_DATA && $past(state) == LINE_IDLE) |-> 1'b0);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  fill;
  logic              pop_take, push_take;

  assign empty     = (fill == '0);
  assign full      = (fill == FULL_CNT);
  assign pop_take  = pop && !empty;
  assign push_take = push && (!full || pop_take);
  assign head_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_take) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_take) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_take)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_take, pop_take})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R4
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);

  // R6
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(fill) && !empty);

  // R5
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty && $stable(rd_ptr));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full && $stable(wr_ptr));
endmodule

// File: rtl/serial_rx_irq_timer.sv
module serial_rx_irq_timer #(
  parameter int LIMIT = 640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  output logic irq
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wait_cnt <= '0;
    else if (!armed)                      wait_cnt <= '0;
    else if (tick && wait_cnt != LIMIT_V) wait_cnt <= wait_cnt + 1'b1;
  end

  assign irq = armed && (wait_cnt == LIMIT_V);

  // R9
  irq_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(armed));
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DEPTH      = 16,
  parameter int IRQ_FRAMES = 4,
  parameter int FRAME_BITS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              baud_tick,
  input  logic              rd_strobe,
  output logic [HOST_W-1:0] rd_word,
  output logic              irq_req
);
  localparam int IRQ_TICKS = IRQ_FRAMES * FRAME_BITS * OVS;
  localparam int PAD_W     = HOST_W - OVERRUN_POS - 1;

  logic              rx_s;
  logic              rx_valid, rx_ferr;
  logic [BYTE_W-1:0] rx_byte, head;
  logic              q_empty, q_full, present;
  logic              ferr_q, ovr_q, dropped;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s));

  serial_rx_deframer #(.OVS(OVS), .DATA_W(BYTE_W)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_s),
    .byte_valid(rx_valid), .byte_data(rx_byte), .frame_err(rx_ferr));

  serial_rx_queue #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_byte),
    .pop(rd_strobe), .head_data(head), .empty(q_empty), .full(q_full));

  serial_rx_irq_timer #(.LIMIT(IRQ_TICKS)) u_irq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .armed(present), .irq(irq_req));

  assign present = !q_empty;
  assign dropped = rx_valid && q_full && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rx_ferr)        ferr_q <= 1'b1;
      else if (rd_strobe) ferr_q <= 1'b0;
      if (dropped)        ovr_q  <= 1'b1;
      else if (rd_strobe) ovr_q  <= 1'b0;
    end
  end

  assign rd_word = {{PAD_W{1'b0}}, ovr_q, ferr_q, present,
                    present ? head : {BYTE_W{1'b0}}};

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(q_full));

  // R7
  ferr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_q) |-> $past(rx_ferr) && $stable(q_empty));

  // R9
  irq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> rd_word[PRESENT_POS]);
endmodule

// File: tb/serial_rx_port_bench.sv
module serial_rx_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        baud_tick = 1'b1;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_word;
  logic        irq_req;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  serial_rx_port u_serial_rx_port (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .rd_strobe(rd_strobe), .rd_word(rd_word), .irq_req(irq_req));

  // {stop_ok, data, expected rd_word}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 8'hA5, 16'h01A5},
    {1'b1, 8'h00, 16'h0100},
    {1'b1, 8'hFF, 16'h01FF},
    {1'b0, 8'h3C, 16'h0200},
    {1'b1, 8'h81, 16'h0181},
    {1'b0, 8'h7E, 16'h0200},
    {1'b1, 8'h01, 16'h0101},
    {1'b1, 8'h80, 16'h0180}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_ok);
    logic [9:0] bits;
    bits = {stop_ok, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_line = bits[i];
      repeat (16) @(negedge clk);
    end
    rx_line = 1'b1;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    gap(5);
    chk("R1 word after reset", rd_word, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq_req}, 16'h0000);
    rst_n = 1'b1;
    gap(5);
    chk("R1 word idle", rd_word, 16'h0000);

    // table walk: R2 decode, R7 framing, R10 pad bits
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v][23:16], VEC[v][24]);
      gap(20);
      chk(VEC[v][24] ? "R2 R10 frame word" : "R7 framing word", rd_word, VEC[v][15:0]);
      strobe();
      gap(3);
      chk("R5 R7 cleared after read", rd_word, 16'h0000);
    end

    // R3 short glitch
    rx_line = 1'b0;
    gap(4);
    rx_line = 1'b1;
    gap(40);
    chk("R3 glitch ignored", rd_word, 16'h0000);
    send_frame(8'h5A, 1'b1);
    gap(20);
    chk("R3 frame after glitch", rd_word, 16'h015A);
    strobe();
    gap(3);

    // R5 reads while empty
    strobe();
    strobe();
    gap(3);
    chk("R5 empty read", rd_word, 16'h0000);
    send_frame(8'hC3, 1'b1);
    gap(20);
    send_frame(8'h96, 1'b1);
    gap(20);
    chk("R5 head after empty reads", rd_word, 16'h01C3);
    strobe();
    gap(2);
    chk("R4 second byte", rd_word, 16'h0196);
    strobe();
    strobe();
    strobe();
    gap(2);
    send_frame(8'h11, 1'b1);
    gap(20);
    chk("R5 pointers intact", rd_word, 16'h0111);
    strobe();
    gap(3);

    // R4 fill, R8 overrun
    for (int k = 0; k < 16; k++) begin
      send_frame(8'(k * 7 + 3), 1'b1);
      gap(20);
    end
    send_frame(8'hEE, 1'b1);
    gap(20);
    chk("R8 overrun flagged, head kept", rd_word, 16'h0503);
    strobe();
    gap(2);
    chk("R8 overrun cleared", rd_word, 16'h010A);
    for (int k = 1; k < 16; k++) begin
      chk("R4 order", rd_word, {8'h01, 8'(k * 7 + 3)});
      strobe();
      gap(1);
    end
    gap(2);
    chk("R8 dropped byte absent", rd_word, 16'h0000);
    chk("R9 irq low when empty", {15'b0, irq_req}, 16'h0000);

    // R9 interrupt delay
    send_frame(8'h42, 1'b1);
    gap(580);
    chk("R9 irq not yet", {15'b0, irq_req}, 16'h0000);
    gap(80);
    chk("R9 irq raised", {15'b0, irq_req}, 16'h0001);
    strobe();
    gap(2);
    chk("R9 irq dropped", {15'b0, irq_req}, 16'h0000);

    // R6 pop swept across the write edge
    for (int off = 0; off < 20; off++) begin
      send_frame(8'(8'h40 + off), 1'b1);
      gap(20);
      fork
        send_frame(8'(8'hA0 + off), 1'b1);
        begin
          gap(140 + off);
          strobe();
        end
      join
      gap(20);
      chk("R6 same-edge push and pop", rd_word, {8'h01, 8'(8'hA0 + off)});
      strobe();
      gap(2);
      chk("R6 no duplicate", rd_word, 16'h0000);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule